// File: doc/BRIEF.md
# Layered Banyan Switch Element

This block is one switching node of a fabric built from several banyan networks stacked on top of each other. It carries bit-serial, frame-synchronised packets. Each node has two horizontal inputs and two horizontal outputs inside its own layer. It also has a vertical input fed from the node above and a vertical output feeding the node below. A new frame begins when `frame_i` is high. In that cycle every input presents the header flit of its packet, and the node decides where each packet goes. The decision holds for the rest of the frame, so the payload flits that follow take the same path as their header.

Live packets that want the same horizontal direction are ranked by a 2-bit priority. Ties are broken in a fixed order: the vertical arrival first, then horizontal input 0, then input 1. The best packet takes its correct output. The next one escapes downward through the vertical output, which has one clock more latency than the horizontal outputs. A third packet is sent out of the wrong horizontal output with its dead flag set. Packets that already arrive dead take no part in the ranking and only fill outputs that are left over. Two parameters give the node's place in the stack. In the top layer the vertical input is ignored, since new packets enter only there. In the bottom layer there is no escape downward: every packet that cannot take its correct direction is dropped.

Top module: `lbs_switch`

## Requirements
- R1: After reset, and until the first frame carries a packet, all three outputs are zero.
- R2: A lone live packet appears on the horizontal output selected by its route bit (flit bit 2: 0 selects output 0, 1 selects output 1). It appears one cycle after its header is presented, with the header unchanged.
- R3: When two live packets want the same horizontal output, the one with the larger priority field (flit bits 4:3) takes it. The other appears unchanged on the vertical output two cycles after the header cycle.
- R4: Among live contenders with equal priority, the vertical input ranks above horizontal input 0, which ranks above horizontal input 1.
- R5: When three live packets want one direction, the best takes it and the second goes down. The third leaves through the other horizontal output with the dead flag (flit bit 1) set.
- R6: A packet arriving with its dead flag set does not displace any live packet. It leaves through a free output, preferring its route direction, then the other horizontal output, then the vertical output, with the dead flag still set.
- R7: The routing chosen in the header cycle (frame_i high) holds until the next frame pulse. Payload flits follow it whatever their bit values, and an input with no packet in the frame reaches no output.
- R8: In the bottom-layer variant, losing and dead packets are dropped: the vertical output stays zero and no output header carries the dead flag.
- R9: In the top-layer variant, the vertical input is ignored entirely.
- R10: Flit bit 0 marks a valid header. Bits above the priority field pass through the node unchanged.
- R11: A frame never produces more valid headers on the horizontal outputs than valid packets entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | High in the header cycle of each frame |
| hin0_i | input | FLIT_W | Horizontal input 0 flit |
| hin1_i | input | FLIT_W | Horizontal input 1 flit |
| vin_i | input | FLIT_W | Vertical input flit from the layer above |
| hout0_o | output | FLIT_W | Horizontal output 0 flit, one cycle latency |
| hout1_o | output | FLIT_W | Horizontal output 1 flit, one cycle latency |
| vout_o | output | FLIT_W | Vertical output flit to the layer below, two cycles latency |

## Verification
The hardest case to reach is the three-way collision. All three inputs must carry live headers with the same route bit in the same frame pulse. The priorities must be arranged so that the expected winner, the downward escape and the dead deflection are each a different input. The bench builds these frames directly, once with equal priorities so that only the tie order decides, and once with priorities that reverse that order. It drives the same frames into top-layer and bottom-layer copies, where the loser must go down or be dropped instead.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    // header flit field positions
    localparam int VALID_BIT = 0;
    localparam int DEAD_BIT  = 1;
    localparam int ROUTE_BIT = 2;
    localparam int PRIO_LSB  = 3;
    localparam int PRIO_W    = 2;
    localparam int HDR_W     = PRIO_LSB + PRIO_W;

    // input and output indices
    localparam int NUM_IN   = 3;
    localparam int NUM_OUT  = 3;
    localparam int IDX_H0   = 0;
    localparam int IDX_H1   = 1;
    localparam int IDX_VERT = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_H0   = 2'd1,
        SRC_H1   = 2'd2,
        SRC_VERT = 2'd3
    } src_e;

    typedef struct packed {
        src_e src;
        logic kill;
    } port_sel_t;

    typedef port_sel_t [NUM_OUT-1:0] sel_vec_t;

    function automatic src_e src_of(input int idx);
        case (idx)
            IDX_H0:   return SRC_H0;
            IDX_H1:   return SRC_H1;
            IDX_VERT: return SRC_VERT;
            default:  return SRC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lbs_rank.sv
module lbs_rank
    import lbs_pkg::*;
(
    input  logic [NUM_IN-1:0]             live_i,
    input  logic [NUM_IN-1:0][PRIO_W-1:0] prio_i,
    output logic [NUM_IN-1:0][1:0]        pos_o
);

    localparam int KEY_W = PRIO_W + 2;

    logic [NUM_IN-1:0][KEY_W-1:0] key;

    // key = priority, then fixed tie order: vertical > h0 > h1
    for (genvar g = 0; g < NUM_IN; g++) begin : g_key
        localparam logic [1:0] TIE = (g == IDX_VERT) ? 2'd2 :
                                     (g == IDX_H0)   ? 2'd1 : 2'd0;
        assign key[g] = {prio_i[g], TIE};
    end

    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            pos_o[i] = 2'd0;
            for (int j = 0; j < NUM_IN; j++) begin
                if (j != i && live_i[j] && key[j] > key[i]) begin
                    pos_o[i] = pos_o[i] + 2'd1;
                end
            end
        end
    end

endmodule

// File: rtl/lbs_arbiter.sv
module lbs_arbiter
    import lbs_pkg::*;
#(
    parameter bit IS_BOTTOM = 1'b0
) (
    input  logic [NUM_IN-1:0]      live_i,
    input  logic [NUM_IN-1:0]      stale_i,
    input  logic [NUM_IN-1:0]      route_i,
    input  logic [NUM_IN-1:0][1:0] pos_i,
    output sel_vec_t               sel_o
);

    localparam int  DN      = 2;
    localparam bit  HAS_DN  = !IS_BOTTOM;

    logic [NUM_OUT-1:0] taken;
    int                 dir;
    int                 oth;
    int                 idx;

    always_comb begin
        taken = '0;
        dir   = 0;
        oth   = 0;
        idx   = 0;
        for (int o = 0; o < NUM_OUT; o++) begin
            sel_o[o].src  = SRC_NONE;
            sel_o[o].kill = 1'b0;
        end

        // live packets, served best-ranked first
        for (int p = 0; p < NUM_IN; p++) begin
            for (int i = 0; i < NUM_IN; i++) begin
                if (live_i[i] && int'(pos_i[i]) == p) begin
                    dir = route_i[i] ? 1 : 0;
                    oth = route_i[i] ? 0 : 1;
                    if (!taken[dir]) begin
                        taken[dir]      = 1'b1;
                        sel_o[dir].src  = src_of(i);
                    end else if (HAS_DN && !taken[DN]) begin
                        taken[DN]       = 1'b1;
                        sel_o[DN].src   = src_of(i);
                    end else if (HAS_DN && !taken[oth]) begin
                        taken[oth]      = 1'b1;
                        sel_o[oth].src  = src_of(i);
                        sel_o[oth].kill = 1'b1;
                    end
                end
            end
        end

        // packets already dead fill what is left, vertical first
        for (int k = 0; k < NUM_IN; k++) begin
            idx = (k == 0) ? IDX_VERT : k - 1;
            if (HAS_DN && stale_i[idx]) begin
                dir = route_i[idx] ? 1 : 0;
                oth = route_i[idx] ? 0 : 1;
                if (!taken[dir]) begin
                    taken[dir]     = 1'b1;
                    sel_o[dir].src = src_of(idx);
                end else if (!taken[oth]) begin
                    taken[oth]     = 1'b1;
                    sel_o[oth].src = src_of(idx);
                end else if (!taken[DN]) begin
                    taken[DN]      = 1'b1;
                    sel_o[DN].src  = src_of(idx);
                end
            end
        end
    end

endmodule

// File: rtl/lbs_lane.sv
module lbs_lane #(
    parameter int FLIT_W = 8,
    parameter int DEPTH  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLIT_W-1:0] flit_i,
    output logic [FLIT_W-1:0] flit_o
);

    typedef struct packed {
        logic [DEPTH-1:0][FLIT_W-1:0] stage;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        lane_d.stage[0] = flit_i;
        for (int k = 1; k < DEPTH; k++) begin
            lane_d.stage[k] = lane_q.stage[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign flit_o = lane_q.stage[DEPTH-1];

endmodule

// File: rtl/lbs_switch.sv
module lbs_switch
    import lbs_pkg::*;
#(
    parameter int FLIT_W    = 8,
    parameter int HOP_LAT   = 1,
    parameter bit IS_TOP    = 1'b0,
    parameter bit IS_BOTTOM = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic [FLIT_W-1:0] hin0_i,
    input  logic [FLIT_W-1:0] hin1_i,
    input  logic [FLIT_W-1:0] vin_i,
    output logic [FLIT_W-1:0] hout0_o,
    output logic [FLIT_W-1:0] hout1_o,
    output logic [FLIT_W-1:0] vout_o
);

    localparam int DN_LAT = HOP_LAT + 1;

    typedef struct packed {
        sel_vec_t sel;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_IN-1:0][FLIT_W-1:0] in_flit;
    logic [NUM_IN-1:0]             live;
    logic [NUM_IN-1:0]             stale;
    logic [NUM_IN-1:0]             route;
    logic [NUM_IN-1:0][PRIO_W-1:0] prio;
    logic [NUM_IN-1:0][1:0]        pos;
    sel_vec_t                      arb_sel;
    sel_vec_t                      act_sel;
    logic [NUM_OUT-1:0][FLIT_W-1:0] lane_in;
    logic [NUM_OUT-1:0][FLIT_W-1:0] lane_out;

    assign in_flit[IDX_H0]   = hin0_i;
    assign in_flit[IDX_H1]   = hin1_i;
    assign in_flit[IDX_VERT] = IS_TOP ? '0 : vin_i;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_hdr
        assign live[g]  = in_flit[g][VALID_BIT] && !in_flit[g][DEAD_BIT];
        assign stale[g] = in_flit[g][VALID_BIT] &&  in_flit[g][DEAD_BIT];
        assign route[g] = in_flit[g][ROUTE_BIT];
        assign prio[g]  = in_flit[g][PRIO_LSB +: PRIO_W];
    end

    lbs_rank u_rank (
        .live_i (live),
        .prio_i (prio),
        .pos_o  (pos)
    );

    lbs_arbiter #(
        .IS_BOTTOM (IS_BOTTOM)
    ) u_arb (
        .live_i  (live),
        .stale_i (stale),
        .route_i (route),
        .pos_i   (pos),
        .sel_o   (arb_sel)
    );

    // latch the routing on the frame pulse, hold it otherwise
    always_comb begin
        state_d = state_q;
        if (frame_i) begin
            state_d.sel = arb_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign act_sel = frame_i ? arb_sel : state_q.sel;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        localparam int LAT = (o == NUM_OUT - 1) ? DN_LAT : HOP_LAT;

        always_comb begin
            case (act_sel[o].src)
                SRC_H0:   lane_in[o] = in_flit[IDX_H0];
                SRC_H1:   lane_in[o] = in_flit[IDX_H1];
                SRC_VERT: lane_in[o] = in_flit[IDX_VERT];
                default:  lane_in[o] = '0;
            endcase
            if (frame_i && act_sel[o].kill) begin
                lane_in[o][DEAD_BIT] = 1'b1;
            end
        end

        lbs_lane #(
            .FLIT_W (FLIT_W),
            .DEPTH  (LAT)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .flit_i (lane_in[o]),
            .flit_o (lane_out[o])
        );
    end

    assign hout0_o = lane_out[0];
    assign hout1_o = lane_out[1];
    assign vout_o  = lane_out[2];

endmodule

// File: rtl/lbs_switch_chk.sv
module lbs_switch_chk
    import lbs_pkg::*;
#(
    parameter int FLIT_W    = 8,
    parameter bit IS_TOP    = 1'b0,
    parameter bit IS_BOTTOM = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_i,
    input logic [FLIT_W-1:0] hin0_i,
    input logic [FLIT_W-1:0] hin1_i,
    input logic [FLIT_W-1:0] vin_i,
    input logic [FLIT_W-1:0] hout0_o,
    input logic [FLIT_W-1:0] hout1_o,
    input logic [FLIT_W-1:0] vout_o
);

    logic [1:0] armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 2'd0;
        end else if (armed_q != 2'd3) begin
            armed_q <= armed_q + 2'd1;
        end
    end

    logic       v_on;
    logic       live0, live1, livev;
    logic [1:0] in_cnt, out_cnt;
    logic       pair_clash, triple_same, lone_h0, no_h;

    assign v_on    = !IS_TOP && vin_i[VALID_BIT];
    assign live0   = hin0_i[VALID_BIT] && !hin0_i[DEAD_BIT];
    assign live1   = hin1_i[VALID_BIT] && !hin1_i[DEAD_BIT];
    assign livev   = v_on && !vin_i[DEAD_BIT];
    assign in_cnt  = 2'(hin0_i[VALID_BIT]) + 2'(hin1_i[VALID_BIT]) + 2'(v_on);
    assign out_cnt = 2'(hout0_o[VALID_BIT]) + 2'(hout1_o[VALID_BIT]);
    assign pair_clash  = live0 && live1 && !v_on &&
                         (hin0_i[ROUTE_BIT] == hin1_i[ROUTE_BIT]);
    assign triple_same = live0 && live1 && livev &&
                         (hin0_i[ROUTE_BIT] == hin1_i[ROUTE_BIT]) &&
                         (vin_i[ROUTE_BIT] == hin0_i[ROUTE_BIT]);
    assign lone_h0 = live0 && !hin1_i[VALID_BIT] && !v_on;
    assign no_h    = !hin0_i[VALID_BIT] && !hin1_i[VALID_BIT];

    // R2
    lone_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q != 2'd0) && $past(frame_i && lone_h0) |->
        (($past(hin0_i[ROUTE_BIT]) ? hout1_o : hout0_o) == $past(hin0_i)));

    // R3
    down_escape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_BOTTOM && (armed_q == 2'd3) && $past(frame_i && pair_clash, 2) |->
        vout_o[VALID_BIT] &&
        (vout_o == $past(hin0_i, 2) || vout_o == $past(hin1_i, 2)));

    // R5
    three_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_TOP && !IS_BOTTOM && (armed_q != 2'd0) &&
        $past(frame_i && triple_same) |->
        (($past(hin0_i[ROUTE_BIT]) ? hout0_o[DEAD_BIT] : hout1_o[DEAD_BIT]) &&
         ($past(hin0_i[ROUTE_BIT]) ? hout0_o[VALID_BIT] : hout1_o[VALID_BIT])));

    // R8
    bottom_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        IS_BOTTOM && (armed_q != 2'd0) && $past(frame_i) |->
        !hout0_o[DEAD_BIT] && !hout1_o[DEAD_BIT]);

    // R9
    top_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        IS_TOP && (armed_q != 2'd0) && $past(frame_i && no_h) |->
        (hout0_o == '0) && (hout1_o == '0));

    // R11
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q != 2'd0) && $past(frame_i) |-> (out_cnt <= $past(in_cnt)));

endmodule

bind lbs_switch lbs_switch_chk #(
    .FLIT_W    (FLIT_W),
    .IS_TOP    (IS_TOP),
    .IS_BOTTOM (IS_BOTTOM)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_i (frame_i),
    .hin0_i  (hin0_i),
    .hin1_i  (hin1_i),
    .vin_i   (vin_i),
    .hout0_o (hout0_o),
    .hout1_o (hout1_o),
    .vout_o  (vout_o)
);

// File: tb/lbs_switch_test.sv
module lbs_switch_test;

    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame = 1'b0;
    logic [FW-1:0] h0 = '0, h1 = '0, v = '0;

    logic [FW-1:0] m_h0, m_h1, m_v;
    logic [FW-1:0] t_h0, t_h1, t_v;
    logic [FW-1:0] b_h0, b_h1, b_v;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    // captured outputs: header cycle (h) and down cycle (d)
    logic [FW-1:0] ch_m0, ch_m1, cd_m;
    logic [FW-1:0] ch_t0, ch_t1, cd_t;
    logic [FW-1:0] ch_b0, ch_b1, cd_b;

    always #5 clk = ~clk;

    lbs_switch #(.FLIT_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame),
        .hin0_i(h0), .hin1_i(h1), .vin_i(v),
        .hout0_o(m_h0), .hout1_o(m_h1), .vout_o(m_v));

    lbs_switch #(.FLIT_W(FW), .IS_TOP(1'b1)) uut_top (
        .clk(clk), .rst_n(rst_n), .frame_i(frame),
        .hin0_i(h0), .hin1_i(h1), .vin_i(v),
        .hout0_o(t_h0), .hout1_o(t_h1), .vout_o(t_v));

    lbs_switch #(.FLIT_W(FW), .IS_BOTTOM(1'b1)) uut_bot (
        .clk(clk), .rst_n(rst_n), .frame_i(frame),
        .hin0_i(h0), .hin1_i(h1), .vin_i(v),
        .hout0_o(b_h0), .hout1_o(b_h1), .vout_o(b_v));

    function automatic logic [FW-1:0] hdr(input logic [2:0] tag, input logic [1:0] prio,
                                          input logic route, input logic dead);
        return {tag, prio, route, dead, 1'b1};
    endfunction

    task automatic chk(input string what, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [FW-1:0] a, input logic [FW-1:0] b, input logic [FW-1:0] c);
        @(negedge clk);
        frame = 1'b1; h0 = a; h1 = b; v = c;
        @(negedge clk);
        frame = 1'b0; h0 = '0; h1 = '0; v = '0;
        ch_m0 = m_h0; ch_m1 = m_h1;
        ch_t0 = t_h0; ch_t1 = t_h1;
        ch_b0 = b_h0; ch_b1 = b_h1;
        @(negedge clk);
        cd_m = m_v; cd_t = t_v; cd_b = b_v;
    endtask

    task automatic t_reset;
        chk("R1 reset hout0", m_h0, 8'h00);
        chk("R1 reset hout1", m_h1, 8'h00);
        chk("R1 reset vout",  m_v,  8'h00);
        chk("R1 reset bottom vout", b_v, 8'h00);
    endtask

    task automatic t_single;
        run_frame(hdr(3'd0, 2'd1, 1'b1, 1'b0), 8'h00, 8'h00);
        chk("R2 lone packet on hout1", ch_m1, 8'h0D);
        chk("R2 hout0 idle", ch_m0, 8'h00);
        chk("R2 vout idle", cd_m, 8'h00);
    endtask

    task automatic t_priority;
        run_frame(8'h19, 8'h09, 8'h00);
        chk("R3 high prio h0 wins", ch_m0, 8'h19);
        chk("R3 loser goes down", cd_m, 8'h09);
        chk("R3 hout1 idle", ch_m1, 8'h00);
        run_frame(8'h05, 8'h15, 8'h00);
        chk("R3 high prio h1 wins", ch_m1, 8'h15);
        chk("R3 h0 goes down", cd_m, 8'h05);
    endtask

    task automatic t_tie;
        run_frame(hdr(3'd1, 2'd2, 1'b1, 1'b0), 8'h00, hdr(3'd5, 2'd2, 1'b1, 1'b0));
        chk("R4 vertical wins tie", ch_m1, 8'hB5);
        chk("R4 h0 goes down", cd_m, 8'h35);
        chk("R4 hout0 idle", ch_m0, 8'h00);
        run_frame(8'h29, 8'h49, 8'h00);
        chk("R4 h0 beats h1 on tie", ch_m0, 8'h29);
        chk("R4 h1 goes down", cd_m, 8'h49);
    endtask

    task automatic t_three;
        run_frame(8'h29, 8'h49, 8'hA9);
        chk("R5 equal prio winner", ch_m0, 8'hA9);
        chk("R5 second down", cd_m, 8'h29);
        chk("R5 third dead", ch_m1, 8'h4B);
        run_frame(8'h35, 8'h5D, 8'hA5);
        chk("R5 prio winner", ch_m1, 8'h5D);
        chk("R5 prio second down", cd_m, 8'h35);
        chk("R5 prio third dead", ch_m0, 8'hA7);
        chk("R8 bottom winner", ch_b1, 8'h5D);
        chk("R8 bottom losers dropped", ch_b0, 8'h00);
        chk("R8 bottom vout zero", cd_b, 8'h00);
        chk("R9 top ignores vertical hout0", ch_t0, 8'h00);
        chk("R9 top h0 down", cd_t, 8'h35);
    endtask

    task automatic t_dead;
        run_frame(8'h3B, 8'h41, 8'h00);
        chk("R6 live keeps route", ch_m0, 8'h41);
        chk("R6 dead deflected", ch_m1, 8'h3B);
        chk("R6 vout idle", cd_m, 8'h00);
        chk("R8 bottom dead dropped", ch_b1, 8'h00);
        run_frame(8'h00, 8'h00, 8'hA7);
        chk("R6 dead vertical on route", ch_m1, 8'hA7);
        chk("R9 top drops vertical", ch_t1, 8'h00);
    endtask

    task automatic t_hold;
        @(negedge clk);
        frame = 1'b1; h0 = 8'h2D; h1 = 8'h00; v = 8'h00;
        @(negedge clk);
        frame = 1'b0; h0 = 8'hA5; h1 = 8'h3C;
        chk("R7 header on hout1", m_h1, 8'h2D);
        @(negedge clk);
        h0 = 8'h5A;
        chk("R7 payload 1 follows", m_h1, 8'hA5);
        chk("R7 unassigned h1 blocked", m_h0, 8'h00);
        @(negedge clk);
        h0 = 8'h00; h1 = 8'h00;
        chk("R7 payload 2 follows", m_h1, 8'h5A);
        chk("R10 route bit in payload ignored", m_h0, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_top;
        run_frame(8'h00, 8'h00, 8'hB9);
        chk("R9 top lone vertical dropped", ch_t0, 8'h00);
        chk("R2 middle lone vertical", ch_m0, 8'hB9);
        run_frame(8'h29, 8'h00, 8'hB9);
        chk("R9 top h0 wins vs vertical", ch_t0, 8'h29);
        chk("R9 top vout idle", cd_t, 8'h00);
        chk("R3 middle vertical wins", ch_m0, 8'hB9);
        chk("R3 middle h0 down", cd_m, 8'h29);
    endtask

    task automatic t_bottom;
        run_frame(8'h19, 8'h09, 8'h00);
        chk("R8 bottom winner", ch_b0, 8'h19);
        chk("R8 bottom loser gone", ch_b1, 8'h00);
        chk("R8 bottom vout zero", cd_b, 8'h00);
        chk("R11 middle no extra header", ch_m1, 8'h00);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_tie();
        t_three();
        t_dead();
        t_hold();
        t_top();
        t_bottom();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule